// File: doc/BRIEF.md
# Die heater controller

This block regulates die temperature by switching banks of constantly toggling flip-flops on and off, so that they act as a heat load. The on-chip temperature sensor delivers readings as a sample value with a one-cycle valid strobe. Each reading is compared with a programmable setpoint and a programmable dead band around it. The controller keeps an enable word in thermometer code: enabled banks always form a contiguous run starting at bank 0. When the die is cold, the next bank up is turned on. When it is hot, the highest enabled bank is turned off. After every change, a settle timer blocks further decisions until the die has had time to respond.

A bang-bang mode turns the same bank array into a single on/off heater. In that mode a cold reading enables every bank and a hot reading disables every bank. The block also reports the number of enabled banks, and whether the settle timer is running, so that surrounding logic can watch the loop.

Top module: `dieheat_ctrl`

## Requirements
- R1: While reset is asserted, `bank_en` is 0, `heat_load` is 0, `level` is 0 and `settling` is 1.
- R2: `bank_en` is always a thermometer code: bit i set implies every bit below i is set. Bank 0 is the first bank turned on and the last bank turned off. This means `bank_en == (1 << level) - 1`.
- R3: In stepped mode (`bang_mode` = 0), an accepted sample with `temp_sample + hyst_band < setpoint` enables exactly one more bank.
- R4: In stepped mode, an accepted sample with `temp_sample > setpoint + hyst_band` disables exactly one bank.
- R5: An accepted sample inside the dead band, both limits included, leaves `bank_en` unchanged.
- R6: The enable word saturates. Raising with all banks on, or lowering with all banks off, changes nothing.
- R7: Any change of `bank_en` loads the settle timer with `settle_cycles`. `settling` then stays high for exactly `settle_cycles` clock cycles, and samples that arrive meanwhile are ignored.
- R8: After reset is released, `settling` remains high and samples are ignored until one settle interval has run.
- R9: In bang-bang mode (`bang_mode` = 1), a cold sample enables all banks, a hot sample disables all banks, and an in-band sample holds the word.
- R10: The flops of an enabled bank invert on every clock. The flops of a disabled bank hold their value.
- R11: `level` equals the number of enabled banks.
- R12: A decision that leaves `bank_en` unchanged does not start the settle timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| temp_sample | input | TEMP_W | Temperature reading from the sensor |
| temp_valid | input | 1 | One-cycle strobe marking a new reading |
| setpoint | input | TEMP_W | Target temperature |
| hyst_band | input | TEMP_W | Half-width of the dead band around the setpoint |
| settle_cycles | input | CNT_W | Wait, in clock cycles, after each change of the enable word |
| bang_mode | input | 1 | 1 selects all-on/all-off control, 0 selects one-bank steps |
| bank_en | output | NUM_BANKS | Thermometer-coded bank enables |
| heat_load | output | NUM_BANKS*FLOPS_PER_BANK | Outputs of the heater flops, grouped by bank |
| level | output | $clog2(NUM_BANKS+1) | Count of enabled banks |
| settling | output | 1 | High while decisions are blocked by the settle timer |

## Verification
The hardest situation to reach from the ports is a sample that arrives while the settle timer is still running. Such a sample must leave no trace, and the timer must not be extended. The stimulus reaches this state by causing a step, then placing a deliberately out-of-band reading in the very next cycle. The bench then confirms that the level did not move and that the busy window lasted exactly the programmed number of cycles. Saturation at both ends is reached by driving repeated extreme readings. The bench also checks that the blocked window is not started by these non-moving decisions.

// File: rtl/dieheat_pkg.sv
package dieheat_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_RAISE = 2'd1,
    CMD_LOWER = 2'd2
  } heat_cmd_e;
endpackage

// File: rtl/dieheat_rst_sync.sv
module dieheat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dieheat_decide.sv
module dieheat_decide
  import dieheat_pkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] temp_sample,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] setpoint,
  input  logic [TEMP_W-1:0] hyst_band,
  input  logic              busy,
  output heat_cmd_e         cmd
);
  localparam int EXT_W = TEMP_W + 1;

  logic [EXT_W-1:0] low_sum;
  logic [EXT_W-1:0] high_lim;
  logic             is_cold;
  logic             is_hot;

  always_comb begin
    // widen by one bit so the band arithmetic cannot wrap
    low_sum  = {1'b0, temp_sample} + {1'b0, hyst_band};
    high_lim = {1'b0, setpoint} + {1'b0, hyst_band};
    is_cold  = low_sum < {1'b0, setpoint};
    is_hot   = {1'b0, temp_sample} > high_lim;
    cmd      = CMD_HOLD;
    if (temp_valid && !busy) begin
      if (is_cold)     cmd = CMD_RAISE;
      else if (is_hot) cmd = CMD_LOWER;
    end
  end
endmodule

// File: rtl/dieheat_therm.sv
module dieheat_therm
  import dieheat_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  heat_cmd_e            cmd,
  input  logic                 bang_mode,
  output logic [NUM_BANKS-1:0] en,
  output logic                 moved
);
  localparam logic [NUM_BANKS-1:0] LSB_ONE = 1;

  logic [NUM_BANKS-1:0] en_q;
  logic [NUM_BANKS-1:0] en_d;

  always_comb begin
    en_d = en_q;
    unique case (cmd)
      CMD_RAISE: en_d = bang_mode ? '1 : ((en_q << 1) | LSB_ONE);
      CMD_LOWER: en_d = bang_mode ? '0 : (en_q >> 1);
      default:   en_d = en_q;
    endcase
  end

  assign moved = (en_d != en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (moved) en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/dieheat_settle.sv
module dieheat_settle #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (pend_q) begin
      cnt_d  = load_val;
      pend_d = 1'b0;
    end else if (start) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    cnt_en = pend_q || start || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign busy = pend_q || (cnt_q != '0);
endmodule

// File: rtl/dieheat_bank.sv
module dieheat_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= ~q_r;
  end

  assign q = q_r;
endmodule

// File: rtl/dieheat_ctrl.sv
module dieheat_ctrl
  import dieheat_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int FLOPS_PER_BANK = 8,
  parameter int TEMP_W         = 12,
  parameter int CNT_W          = 16,
  localparam int LVL_W         = $clog2(NUM_BANKS + 1),
  localparam int LOAD_W        = NUM_BANKS * FLOPS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_sample,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] setpoint,
  input  logic [TEMP_W-1:0] hyst_band,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic              bang_mode,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic [LOAD_W-1:0] heat_load,
  output logic [LVL_W-1:0]  level,
  output logic              settling
);
  logic      rst_n_int;
  heat_cmd_e cmd;
  logic      moved;

  dieheat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dieheat_decide #(.TEMP_W(TEMP_W)) u_decide (
    .temp_sample (temp_sample),
    .temp_valid  (temp_valid),
    .setpoint    (setpoint),
    .hyst_band   (hyst_band),
    .busy        (settling),
    .cmd         (cmd)
  );

  dieheat_therm #(.NUM_BANKS(NUM_BANKS)) u_therm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd       (cmd),
    .bang_mode (bang_mode),
    .en        (bank_en),
    .moved     (moved)
  );

  dieheat_settle #(.CNT_W(CNT_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (moved),
    .load_val (settle_cycles),
    .busy     (settling)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dieheat_bank #(.WIDTH(FLOPS_PER_BANK)) u_bank (
      .clk   (clk),
      .rst_n (rst_n_int),
      .en    (bank_en[b]),
      .q     (heat_load[b*FLOPS_PER_BANK +: FLOPS_PER_BANK])
    );
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_BANKS; i++) level = level + LVL_W'(bank_en[i]);
  end
endmodule

// File: rtl/dieheat_chk.sv
module dieheat_chk #(
  parameter int NUM_BANKS      = 4,
  parameter int FLOPS_PER_BANK = 8,
  parameter int CNT_W          = 16
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                bang_mode,
  input logic [CNT_W-1:0]                    settle_cycles,
  input logic [NUM_BANKS-1:0]                bank_en,
  input logic [NUM_BANKS*FLOPS_PER_BANK-1:0] heat_load,
  input logic                                settling
);
  localparam logic [NUM_BANKS-1:0] ONE_V = 1;

  // R2
  therm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_en + ONE_V) & bank_en) == '0);

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bang_mode |=> ($countones(bank_en ^ $past(bank_en)) <= 1));

  // R7
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settling |=> $stable(bank_en));

  // R7
  move_starts_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_en != $past(bank_en)) && (settle_cycles != '0)) |-> settling);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    // R10
    toggle_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en[b] |=> (heat_load[b*FLOPS_PER_BANK +: FLOPS_PER_BANK] ==
                      ~$past(heat_load[b*FLOPS_PER_BANK +: FLOPS_PER_BANK])));
    // R10
    static_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en[b] |=> $stable(heat_load[b*FLOPS_PER_BANK +: FLOPS_PER_BANK]));
  end
endmodule

bind dieheat_ctrl dieheat_chk #(
  .NUM_BANKS      (NUM_BANKS),
  .FLOPS_PER_BANK (FLOPS_PER_BANK),
  .CNT_W          (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bang_mode     (bang_mode),
  .settle_cycles (settle_cycles),
  .bank_en       (bank_en),
  .heat_load     (heat_load),
  .settling      (settling)
);

// File: tb/tb_dieheat_ctrl.sv
module tb_dieheat_ctrl;
  localparam int NB    = 4;
  localparam int FPB   = 8;
  localparam int TW    = 12;
  localparam int CW    = 16;
  localparam int NVEC  = 16;
  localparam int WAIT_N = 20;

  logic          clk;
  logic          rst_n;
  logic [TW-1:0] temp_sample;
  logic          temp_valid;
  logic [TW-1:0] setpoint;
  logic [TW-1:0] hyst_band;
  logic [CW-1:0] settle_cycles;
  logic          bang_mode;
  logic [NB-1:0] bank_en;
  logic [NB*FPB-1:0] heat_load;
  logic [2:0]    level;
  logic          settling;

  int checks = 0;
  int fails  = 0;

  // {bang_mode, temp_sample, expected level}; setpoint 1000, band 10
  localparam logic [15:0] VECS [0:NVEC-1] = '{
    {1'b0, 12'd980,  3'd1},  // R3 cold
    {1'b0, 12'd985,  3'd2},  // R3 cold
    {1'b0, 12'd990,  3'd2},  // R5 lower band edge
    {1'b0, 12'd1010, 3'd2},  // R5 upper band edge
    {1'b0, 12'd1011, 3'd1},  // R4 hot
    {1'b0, 12'd1011, 3'd0},  // R4 hot
    {1'b0, 12'd1050, 3'd0},  // R6 floor
    {1'b0, 12'd0,    3'd1},
    {1'b0, 12'd0,    3'd2},
    {1'b0, 12'd0,    3'd3},
    {1'b0, 12'd0,    3'd4},
    {1'b0, 12'd0,    3'd4},  // R6 ceiling
    {1'b1, 12'd2000, 3'd0},  // R9 all off
    {1'b1, 12'd1000, 3'd0},  // R9 in band
    {1'b1, 12'd500,  3'd4},  // R9 all on
    {1'b0, 12'd2000, 3'd3}   // R4 stepped again
  };

  dieheat_ctrl #(
    .NUM_BANKS(NB), .FLOPS_PER_BANK(FPB), .TEMP_W(TW), .CNT_W(CW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .temp_sample(temp_sample), .temp_valid(temp_valid),
    .setpoint(setpoint), .hyst_band(hyst_band), .settle_cycles(settle_cycles),
    .bang_mode(bang_mode), .bank_en(bank_en), .heat_load(heat_load),
    .level(level), .settling(settling)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 1000 && settling; n++) @(negedge clk);
  endtask

  task automatic apply(input logic bm, input logic [TW-1:0] t);
    bang_mode   = bm;
    temp_sample = t;
    temp_valid  = 1'b1;
    @(negedge clk);
    temp_valid  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NB*FPB-1:0] h0;
    int win;
    rst_n = 1'b0; temp_valid = 1'b0; temp_sample = '0;
    setpoint = 12'd1000; hyst_band = 12'd10; settle_cycles = CW'(WAIT_N);
    bang_mode = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(bank_en == '0, "R1 bank_en", bank_en, 0);
    check(heat_load == '0, "R1 heat_load", heat_load, 0);
    check(level == '0, "R1 level", level, 0);
    check(settling == 1'b1, "R1 settling", settling, 1);
    rst_n = 1'b1;
    @(negedge clk);
    apply(1'b0, 12'd0);
    // R8 first sample after reset is ignored
    check(level == 3'd0, "R8 level", level, 0);
    check(settling == 1'b1, "R8 settling", settling, 1);

    for (int v = 0; v < NVEC; v++) begin
      wait_idle();
      apply(VECS[v][15], VECS[v][14:3]);
      check(level == VECS[v][2:0], $sformatf("R3/R4/R5/R6/R9/R11 vec%0d level", v),
            level, VECS[v][2:0]);
      check(bank_en == NB'((1 << VECS[v][2:0]) - 1), $sformatf("R2 vec%0d bank_en", v),
            bank_en, (1 << VECS[v][2:0]) - 1);
    end

    // R7 busy window length after a step (level 3 -> 4)
    wait_idle();
    apply(1'b0, 12'd0);
    win = 0;
    for (int n = 0; n < 100 && settling; n++) begin
      win++;
      @(negedge clk);
    end
    check(win == WAIT_N, "R7 window", win, WAIT_N);
    check(level == 3'd4, "R7 level", level, 4);

    // R12 saturated raise does not start timer
    apply(1'b0, 12'd0);
    check(settling == 1'b0, "R12 settling", settling, 0);
    check(level == 3'd4, "R12 level", level, 4);

    // R7 sample during wait ignored
    apply(1'b0, 12'd2000);
    check(level == 3'd3, "R7 step", level, 3);
    apply(1'b0, 12'd2000);
    check(level == 3'd3, "R7 ignored", level, 3);

    // R10 toggling of enabled banks, static disabled bank
    h0 = heat_load;
    @(negedge clk);
    check(heat_load[3*FPB-1:0] == ~h0[3*FPB-1:0], "R10 on banks",
          heat_load[3*FPB-1:0], ~h0[3*FPB-1:0]);
    check(heat_load[NB*FPB-1:3*FPB] == h0[NB*FPB-1:3*FPB], "R10 off bank",
          heat_load[NB*FPB-1:3*FPB], h0[NB*FPB-1:3*FPB]);

    finish_run();
  end
endmodule